// File: doc/BRIEF.md
# Serial Read Port with Tap-Loaded Pointer

This block is the serial output side of a video memory. It keeps a static register of 512 positions, each one a 16-bit word, and a serial pointer that selects the position read next. Each serial-clock pulse (`sc_tick`, one cycle wide in the `clk` domain) presents the word at the pointer on the serial data output and moves the pointer forward by one. After the last position the pointer returns to zero. A transfer strobe loads the pointer with a tap address. A parallel load stream fills the register one word per beat.

An active-low output enable controls the serial data outputs and a half indicator. The half indicator shows whether the pointer is in the lower or upper 256 positions. The outputs are described as a pad-side pair: a value bus plus a drive enable (`out_drive`). The pad ring places the three-state buffers. While outputs are disabled the pointer keeps counting, so a later enable resumes at the position the clocks have reached. The register holds its contents with no refresh, and the serial clock can stay idle for as long as needed.

The load stream is valid/ready. `ld_ready` drops in any cycle that carries a transfer strobe. A beat is taken only when `ld_valid` and `ld_ready` are both high. A stalled beat must hold its address and data until it is accepted.

Top module: `sap_serial_port`

## Requirements
- R1: After reset the pointer is 0, the presented word is 0 and the half indicator is 0.
- R2: A cycle with `sc_tick` high and `xfer_req` low presents the word at the current pointer on `sq_data` after that clock edge, and advances the pointer by one.
- R3: From position 511 a tick sets the pointer to position 0.
- R4: A cycle with `xfer_req` high loads the pointer with `xfer_tap`. The next tick presents the word at that tap.
- R5: When `xfer_req` and `sc_tick` are high in the same cycle, the transfer wins: the pointer becomes the tap and the presented word does not change.
- R6: While `out_en_n` is 1, `out_drive` is 0 and `sq_data` and `qsf` read 0 (high impedance at the pad). While it is 0, `out_drive` is 1 and both outputs carry their values.
- R7: Ticks advance the pointer while `out_en_n` is 1.
- R8: `qsf` is the top bit of the pointer: 0 for positions 0–255 and 1 for positions 256–511. It takes the tap's value in the cycle after a transfer.
- R9: `ld_ready` is 0 in a cycle with `xfer_req` high. Such a beat writes nothing. An accepted beat writes `ld_data` at `ld_addr`. A tick that reads the address being written in the same cycle presents the old word.
- R10: With no tick and no transfer, the presented word and the pointer keep their values for any number of cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sc_tick | input | 1 | Serial-clock pulse, one per word |
| out_en_n | input | 1 | Active-low enable for serial data and half indicator |
| xfer_req | input | 1 | Transfer strobe, loads the pointer |
| xfer_tap | input | 9 | Tap position loaded on a transfer |
| ld_valid | input | 1 | Load beat valid |
| ld_ready | output | 1 | Load beat accepted this cycle |
| ld_addr | input | 9 | Position written by a load beat |
| ld_data | input | 16 | Word written by a load beat |
| sq_data | output | 16 | Serial data word (0 when not driven) |
| qsf | output | 1 | Half indicator (0 when not driven) |
| out_drive | output | 1 | Pad drive enable for sq_data and qsf |

## Verification
The case that is hardest to reach from the ports is position tracking across a disabled window. While `out_en_n` is high, the outputs show no trace of the pointer. A miscount only shows up after re-enable, as the wrong word. The stimulus disables the outputs and sends a known number of ticks. It then re-enables the outputs and checks that the next word is from the position the ticks must have reached. The same-cycle cases are driven on purpose: a transfer together with a tick, and a load together with a tick at the same address. Before both, the pointer is steered with a transfer so that the colliding address is the one read.

// File: rtl/sap_pkg.sv
package sap_pkg;

  typedef enum logic [1:0] {
    PTR_HOLD = 2'd0,
    PTR_STEP = 2'd1,
    PTR_LOAD = 2'd2
  } ptr_op_e;

  // Transfer outranks a step, a step outranks holding.
  function automatic ptr_op_e pick_op(input logic load, input logic step);
    if (load)      return PTR_LOAD;
    else if (step) return PTR_STEP;
    else           return PTR_HOLD;
  endfunction

endpackage

// File: rtl/sap_ptr_ctl.sv
module sap_ptr_ctl
  import sap_pkg::*;
#(
  parameter int DEPTH = 512,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  ptr_op_e       op,
  input  logic [AW-1:0] tap,
  output logic [AW-1:0] ptr,
  output logic          half
);

  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [AW-1:0] ptr_nxt;

  always_comb begin
    case (op)
      PTR_LOAD: ptr_nxt = tap;
      PTR_STEP: ptr_nxt = (ptr == LAST) ? '0 : AW'(ptr + 1'b1);
      default:  ptr_nxt = ptr;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr  <= '0;
      half <= 1'b0;
    end else begin
      ptr  <= ptr_nxt;
      half <= ptr_nxt[AW-1];
    end
  end

endmodule

// File: rtl/sap_word_store.sv
module sap_word_store #(
  parameter int DEPTH = 512,
  parameter int DW    = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_q
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  // Nonblocking read returns the pre-write word on an address collision.
  always_ff @(posedge clk) begin
    if (!rst_n)     rd_q <= '0;
    else if (rd_en) rd_q <= mem[rd_addr];
  end

endmodule

// File: rtl/sap_out_gate.sv
module sap_out_gate #(
  parameter int DW = 16
) (
  input  logic          out_en_n,
  input  logic [DW-1:0] word,
  input  logic          half,
  output logic [DW-1:0] data_o,
  output logic          half_o,
  output logic          drive_o
);

  assign drive_o = ~out_en_n;
  assign half_o  = half & drive_o;

  for (genvar b = 0; b < DW; b++) begin : g_lane
    assign data_o[b] = word[b] & drive_o;
  end

endmodule

// File: rtl/sap_serial_port.sv
module sap_serial_port
  import sap_pkg::*;
#(
  parameter int DEPTH = 512,
  parameter int DW    = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sc_tick,
  input  logic          out_en_n,
  input  logic          xfer_req,
  input  logic [AW-1:0] xfer_tap,
  input  logic          ld_valid,
  output logic          ld_ready,
  input  logic [AW-1:0] ld_addr,
  input  logic [DW-1:0] ld_data,
  output logic [DW-1:0] sq_data,
  output logic          qsf,
  output logic          out_drive
);

  ptr_op_e       op;
  logic [AW-1:0] ptr_q;
  logic          half_q;
  logic [DW-1:0] rd_q;

  assign op       = pick_op(xfer_req, sc_tick);
  assign ld_ready = ~xfer_req;

  sap_ptr_ctl #(.DEPTH(DEPTH)) i_ptr (
    .clk  (clk),
    .rst_n(rst_n),
    .op   (op),
    .tap  (xfer_tap),
    .ptr  (ptr_q),
    .half (half_q)
  );

  sap_word_store #(.DEPTH(DEPTH), .DW(DW)) i_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (ld_valid & ld_ready),
    .wr_addr(ld_addr),
    .wr_data(ld_data),
    .rd_en  (op == PTR_STEP),
    .rd_addr(ptr_q),
    .rd_q   (rd_q)
  );

  sap_out_gate #(.DW(DW)) i_gate (
    .out_en_n(out_en_n),
    .word    (rd_q),
    .half    (half_q),
    .data_o  (sq_data),
    .half_o  (qsf),
    .drive_o (out_drive)
  );

endmodule

// File: rtl/sap_serial_port_chk.sv
module sap_serial_port_chk #(
  parameter int DEPTH = 512,
  parameter int DW    = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sc_tick,
  input logic          out_en_n,
  input logic          xfer_req,
  input logic [AW-1:0] xfer_tap,
  input logic          ld_ready,
  input logic [DW-1:0] sq_data,
  input logic          qsf,
  input logic          out_drive,
  input logic [AW-1:0] ptr,
  input logic [DW-1:0] word
);

  // R4
  xfer_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_req |=> ptr == $past(xfer_tap));

  // R2 R3
  step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sc_tick && !xfer_req) |=>
      (($past(ptr) == AW'(DEPTH - 1)) ? (ptr == '0) : (ptr == AW'($past(ptr) + 1'b1))));

  // R5
  xfer_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sc_tick && xfer_req) |=> $stable(word));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sc_tick && !xfer_req) |=> ($stable(word) && $stable(ptr)));

  // R6
  quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_en_n |-> (!out_drive && sq_data == '0 && !qsf));

  // R6
  drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_en_n |-> (out_drive && sq_data == word));

  // R8
  half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_en_n |-> (qsf == ptr[AW-1]));

  // R7
  free_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_en_n && sc_tick && !xfer_req) |=> ptr != $past(ptr));

  // R9
  ld_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_req |-> !ld_ready);

endmodule

bind sap_serial_port sap_serial_port_chk #(.DEPTH(DEPTH), .DW(DW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .sc_tick  (sc_tick),
  .out_en_n (out_en_n),
  .xfer_req (xfer_req),
  .xfer_tap (xfer_tap),
  .ld_ready (ld_ready),
  .sq_data  (sq_data),
  .qsf      (qsf),
  .out_drive(out_drive),
  .ptr      (ptr_q),
  .word     (rd_q)
);

// File: tb/test_sap_serial_port.sv
`timescale 1ns/1ps
module test_sap_serial_port;

  localparam int DEPTH = 512;
  localparam int DW    = 16;
  localparam int AW    = 9;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sc_tick = 1'b0;
  logic          out_en_n = 1'b1;
  logic          xfer_req = 1'b0;
  logic [AW-1:0] xfer_tap = '0;
  logic          ld_valid = 1'b0;
  logic          ld_ready;
  logic [AW-1:0] ld_addr = '0;
  logic [DW-1:0] ld_data = '0;
  logic [DW-1:0] sq_data;
  logic          qsf;
  logic          out_drive;

  always #4 clk = ~clk;

  sap_serial_port i_sap_serial_port (
    .clk(clk), .rst_n(rst_n), .sc_tick(sc_tick), .out_en_n(out_en_n),
    .xfer_req(xfer_req), .xfer_tap(xfer_tap), .ld_valid(ld_valid),
    .ld_ready(ld_ready), .ld_addr(ld_addr), .ld_data(ld_data),
    .sq_data(sq_data), .qsf(qsf), .out_drive(out_drive)
  );

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // Bench model, built from the requirements
  logic [DW-1:0] mem_m [DEPTH];
  logic [AW-1:0] ptr_m = '0;
  logic [DW-1:0] last_m = '0;

  // Scoreboard: {drive, qsf, data}
  logic [DW+1:0] exp_q[$];
  string         tag_q[$];

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] pat(int i);
    return DW'(i * 40503) ^ 16'hC3A5;
  endfunction

  // Monitor: each tick without a transfer produces one scoreboard item
  always @(posedge clk) begin
    if (rst_n && sc_tick && !xfer_req) begin
      #2;
      if (exp_q.size() == 0) begin
        check("R2 scoreboard empty", 32'd1, 32'd0);
      end else begin
        logic [DW+1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, {14'd0, out_drive, qsf, sq_data}, {14'd0, e});
      end
    end
  end

  // Driver: one tick, expected item pushed from the model
  task automatic do_tick(string tag);
    logic [AW-1:0] nxt;
    @(negedge clk);
    sc_tick = 1'b1;
    nxt = (ptr_m == AW'(DEPTH - 1)) ? '0 : ptr_m + 1'b1;
    last_m = mem_m[ptr_m];
    if (out_en_n) exp_q.push_back('0);
    else          exp_q.push_back({1'b1, nxt[AW-1], mem_m[ptr_m]});
    tag_q.push_back(tag);
    ptr_m = nxt;
    @(negedge clk);
    sc_tick = 1'b0;
  endtask

  task automatic do_xfer(logic [AW-1:0] tap);
    @(negedge clk);
    xfer_req = 1'b1;
    xfer_tap = tap;
    @(negedge clk);
    xfer_req = 1'b0;
    ptr_m = tap;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 R6: reset state with outputs disabled
    check("R6 drive off", {31'd0, out_drive}, 32'd0);
    check("R6 data quiet", {16'd0, sq_data}, 32'd0);
    out_en_n = 1'b0;
    #1;
    check("R1 reset word", {16'd0, sq_data}, 32'd0);
    check("R1 reset half", {31'd0, qsf}, 32'd0);
    check("R6 drive on", {31'd0, out_drive}, 32'd1);

    // R9: fill the register
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge clk);
      ld_valid = 1'b1;
      ld_addr  = AW'(i);
      ld_data  = pat(i);
      mem_m[i] = pat(i);
      if (i == 0) begin
        #1;
        check("R9 ready idle", {31'd0, ld_ready}, 32'd1);
      end
    end
    @(negedge clk);
    ld_valid = 1'b0;

    // R2: sequential words from position 0
    for (int k = 0; k < 5; k++) do_tick("R2 sequential");

    // R8 R4: transfer into upper half, then lower half
    do_xfer(9'd300);
    check("R8 half after upper tap", {31'd0, qsf}, 32'd1);
    do_xfer(9'd254);
    check("R8 half after lower tap", {31'd0, qsf}, 32'd0);
    for (int k = 0; k < 4; k++) do_tick("R4 R8 across halves");

    // R5: transfer and tick together
    @(negedge clk);
    xfer_req = 1'b1;
    xfer_tap = 9'd400;
    sc_tick  = 1'b1;
    @(negedge clk);
    xfer_req = 1'b0;
    sc_tick  = 1'b0;
    ptr_m    = 9'd400;
    check("R5 word kept", {16'd0, sq_data}, {16'd0, last_m});
    check("R5 half from tap", {31'd0, qsf}, 32'd1);
    do_tick("R5 resumes at tap");

    // R7 R6: ticks while disabled
    @(negedge clk);
    out_en_n = 1'b1;
    for (int k = 0; k < 3; k++) do_tick("R6 R7 disabled tick");
    @(negedge clk);
    out_en_n = 1'b0;
    do_tick("R7 position after disabled ticks");

    // R3: wrap
    do_xfer(9'd510);
    for (int k = 0; k < 4; k++) do_tick("R3 wrap");

    // R10: idle hold
    begin
      logic [DW-1:0] held;
      held = sq_data;
      repeat (50) @(negedge clk);
      check("R10 word held", {16'd0, sq_data}, {16'd0, held});
      do_tick("R10 pointer held");
    end

    // R9: load blocked by transfer
    @(negedge clk);
    xfer_req = 1'b1;
    xfer_tap = 9'd77;
    ld_valid = 1'b1;
    ld_addr  = 9'd77;
    ld_data  = 16'hBEEF;
    #1;
    check("R9 ready low on transfer", {31'd0, ld_ready}, 32'd0);
    @(negedge clk);
    xfer_req = 1'b0;
    ld_valid = 1'b0;
    ptr_m = 9'd77;
    do_tick("R9 blocked beat wrote nothing");

    // R9: write and read the same position in one cycle
    do_xfer(9'd120);
    @(negedge clk);
    sc_tick  = 1'b1;
    ld_valid = 1'b1;
    ld_addr  = 9'd120;
    ld_data  = 16'h1234;
    exp_q.push_back({1'b1, 1'b0, mem_m[120]});
    tag_q.push_back("R9 collision returns old word");
    mem_m[120] = 16'h1234;
    ptr_m = 9'd121;
    @(negedge clk);
    sc_tick  = 1'b0;
    ld_valid = 1'b0;
    do_xfer(9'd120);
    do_tick("R9 new word after collision");

    repeat (3) @(negedge clk);
    check("R2 scoreboard drained", exp_q.size(), 32'd0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule